// File: doc/BRIEF.md
# Audio Codec Link Controller with Two DMA Channels

This block is the register front end of an audio codec link. Software talks to it through a word-addressed 32-bit register window. One group of four registers stages a codec register access (control, codec register address, outgoing data, incoming data). Writing the control word with its request bit set sends a single-cycle interrupt pulse. The pulse goes to a request line for codec writes and to a reply line for codec reads. The serial link engine listens on these lines.

Two DMA channels move sample bytes, one for playback and one for capture. Each has a control word (bit 0 enables the channel), a buffer address and a remaining byte count. A sample stream port offers a number of bytes in a cycle, and the channel answers in that same cycle with the number it takes. At the next clock edge the address moves forward by that amount and the count goes down by it. If the channel is enabled and the count has just reached zero, a single-cycle done pulse follows. The stream is 48 kHz stereo with signed 16-bit samples, so one frame is four bytes. The stream port carries whole byte counts and the block does not enforce frame alignment.

Top module: `aclink_ctrl`

## Requirements
- R1: The word index is bus_addr shifted right by two; bits 1:0 are ignored. Slots 0..10 hold in order: codec control, codec address, codec data out, codec data in, playback control, playback address, playback remaining, reserved, capture control, capture address, capture remaining. Slots 1..6 and 8..10 read back the last written 32-bit value. bus_rdata is combinational from bus_addr.
- R2: Slot 7 and slots 11..15 always read zero, and writes to them change no register and raise no pulse.
- R3: A write to slot 0 with bit 0 = 1 and bit 1 = 1 drives irq_codec_req high for exactly the one cycle after the write edge. irq_codec_rsp stays low.
- R4: A write to slot 0 with bit 0 = 1 and bit 1 = 0 drives irq_codec_rsp high for exactly the one cycle after the write edge. Writes with bit 0 = 0 raise neither pulse.
- R5: Slot 0 reads back the written value with bit 0 forced to zero.
- R6: With offer valid, a channel's take is min(remaining, offered bytes), in the same cycle. With offer not valid, the take is 0.
- R7: At the edge that ends a cycle with a nonzero take, the channel address grows by the take and the remaining count shrinks by it.
- R8: If a nonzero take brings the remaining count to zero while the control bit 0 (the value held before that edge) is 1, a one-cycle done pulse follows: irq_play_done for playback, irq_cap_done for capture. If bit 0 is 0, no pulse follows.
- R9: A zero take leaves the address and count unchanged and raises no done pulse.
- R10: Reset clears every register to zero. play_active and cap_active equal bit 0 of their channel control registers.
- R11: In a cycle where the bus writes a channel's address or remaining slot, that channel's take is 0 and the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_codec_req | output | 1 | Codec write request pulse |
| irq_codec_rsp | output | 1 | Codec read reply pulse |
| irq_play_done | output | 1 | Playback done pulse |
| irq_cap_done | output | 1 | Capture done pulse |
| play_active | output | 1 | Playback stream enabled |
| play_offer_vld | input | 1 | Playback port offers bytes |
| play_offer_bytes | input | CNT_W | Bytes offered |
| play_take_bytes | output | CNT_W | Bytes taken this cycle |
| cap_active | output | 1 | Capture stream enabled |
| cap_offer_vld | input | 1 | Capture port offers bytes |
| cap_offer_bytes | input | CNT_W | Bytes offered |
| cap_take_bytes | output | CNT_W | Bytes taken this cycle |

## Verification
Each channel's count feeds its take in the same cycle, so a corrupted count shows on the take port on the very next offer. It also shows on the register readback right after the edge. A bad address does not touch the take or the pulses, so it is visible only through readback, which the bench does for every slot after every cycle. A done pulse that is missing, late or spurious shows one cycle after the edge that emptied the count. The codec pulses show in the cycle after the control write.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;
    localparam int WORD_W = 32;

    localparam int SLOT_CC  = 0;
    localparam int SLOT_CA  = 1;
    localparam int SLOT_CDO = 2;
    localparam int SLOT_CDI = 3;
    localparam int SLOT_PB  = 4;
    localparam int SLOT_CP  = 8;
    localparam int NUM_SLOTS = 11;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] rem;
        logic              done;
    } chan_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] dout;
        logic [WORD_W-1:0] din;
        logic              req;
        logic              rsp;
    } codec_state_t;
endpackage

// File: rtl/aclink_codec_regs.sv
`timescale 1ns/1ps
module aclink_codec_regs
    import aclink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] dout_o,
    output logic [WORD_W-1:0] din_o,
    output logic              req_o,
    output logic              rsp_o
);
    codec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.req = 1'b0;
        st_d.rsp = 1'b0;
        if (wr_en[0]) begin
            st_d.ctrl = {wdata[WORD_W-1:1], 1'b0};
            if (wdata[0]) begin
                st_d.req = wdata[1];
                st_d.rsp = !wdata[1];
            end
        end
        if (wr_en[1]) st_d.addr = wdata;
        if (wr_en[2]) st_d.dout = wdata;
        if (wr_en[3]) st_d.din  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign addr_o = st_q.addr;
    assign dout_o = st_q.dout;
    assign din_o  = st_q.din;
    assign req_o  = st_q.req;
    assign rsp_o  = st_q.rsp;

    assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && rsp_o));
    assert_req_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(wr_en[0] && wdata[1:0] == 2'b11));
    assert_rsp_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_o |-> $past(wr_en[0] && wdata[1:0] == 2'b01));
    assert_ctrl_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en[0]) |-> ctrl_o[WORD_W-1:1] == $past(wdata[WORD_W-1:1]));
endmodule

// File: rtl/aclink_dma_chan.sv
`timescale 1ns/1ps
module aclink_dma_chan
    import aclink_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic              wr_rem,
    input  logic [WORD_W-1:0] wdata,
    input  logic              offer_vld,
    input  logic [CNT_W-1:0]  offer_bytes,
    output logic [CNT_W-1:0]  take_bytes,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] rem_o,
    output logic              done_o,
    output logic              active_o
);
    localparam int PAD_W = WORD_W - CNT_W;

    chan_state_t       st_d, st_q;
    logic [WORD_W-1:0] offer_ext;
    logic [WORD_W-1:0] take_w;
    logic              blocked;

    always_comb begin
        offer_ext = {{PAD_W{1'b0}}, offer_bytes};
        blocked   = wr_addr || wr_rem;
        take_w    = '0;
        if (offer_vld && !blocked)
            take_w = (st_q.rem < offer_ext) ? st_q.rem : offer_ext;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (wr_ctrl) st_d.ctrl = wdata;
        if (wr_addr) st_d.addr = wdata;
        if (wr_rem)  st_d.rem  = wdata;
        if (take_w != '0) begin
            st_d.addr = st_q.addr + take_w;
            st_d.rem  = st_q.rem - take_w;
            st_d.done = st_q.ctrl[0] && (st_q.rem == take_w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_bytes = take_w[CNT_W-1:0];
    assign ctrl_o     = st_q.ctrl;
    assign addr_o     = st_q.addr;
    assign rem_o      = st_q.rem;
    assign done_o     = st_q.done;
    assign active_o   = st_q.ctrl[0];

    assert_take_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ({{PAD_W{1'b0}}, take_bytes} <= st_q.rem) && (take_bytes <= offer_bytes));
    assert_take_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr || wr_rem || !offer_vld) |-> take_bytes == '0);
    assert_conserve_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_addr || wr_rem) |-> (addr_o + rem_o) == $past(addr_o + rem_o));
    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o == '0) && $past(active_o) && ($past(take_bytes) != '0));
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take_bytes) == '0 && !$past(wr_addr || wr_rem))
            |-> ($stable(addr_o) && $stable(rem_o) && !done_o));
endmodule

// File: rtl/aclink_ctrl.sv
`timescale 1ns/1ps
module aclink_ctrl
    import aclink_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_codec_req,
    output logic              irq_codec_rsp,
    output logic              irq_play_done,
    output logic              irq_cap_done,
    output logic              play_active,
    input  logic              play_offer_vld,
    input  logic [CNT_W-1:0]  play_offer_bytes,
    output logic [CNT_W-1:0]  play_take_bytes,
    output logic              cap_active,
    input  logic              cap_offer_vld,
    input  logic [CNT_W-1:0]  cap_offer_bytes,
    output logic [CNT_W-1:0]  cap_take_bytes
);
    localparam int SLOT_W  = ADDR_W - 2;
    localparam int N_INDEX = 1 << SLOT_W;
    localparam int N_CHAN  = 2;

    logic [SLOT_W-1:0]  slot;
    logic [N_INDEX-1:0] wr_hit;
    logic               unused_lo;

    logic [WORD_W-1:0] cc_q, ca_q, cdo_q, cdi_q;
    logic [WORD_W-1:0] ch_ctrl [N_CHAN];
    logic [WORD_W-1:0] ch_addr [N_CHAN];
    logic [WORD_W-1:0] ch_rem  [N_CHAN];
    logic              ch_done [N_CHAN];
    logic              ch_act  [N_CHAN];
    logic              ch_vld  [N_CHAN];
    logic [CNT_W-1:0]  ch_offer[N_CHAN];
    logic [CNT_W-1:0]  ch_take [N_CHAN];

    assign slot      = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];

    always_comb begin
        wr_hit = '0;
        if (bus_sel && bus_we) wr_hit[slot] = 1'b1;
    end

    aclink_codec_regs u_codec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_hit[SLOT_CDI:SLOT_CC]),
        .wdata  (bus_wdata),
        .ctrl_o (cc_q),
        .addr_o (ca_q),
        .dout_o (cdo_q),
        .din_o  (cdi_q),
        .req_o  (irq_codec_req),
        .rsp_o  (irq_codec_rsp)
    );

    assign ch_vld[0]   = play_offer_vld;
    assign ch_offer[0] = play_offer_bytes;
    assign ch_vld[1]   = cap_offer_vld;
    assign ch_offer[1] = cap_offer_bytes;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        localparam int BASE = (c == 0) ? SLOT_PB : SLOT_CP;
        aclink_dma_chan #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_ctrl     (wr_hit[BASE]),
            .wr_addr     (wr_hit[BASE+1]),
            .wr_rem      (wr_hit[BASE+2]),
            .wdata       (bus_wdata),
            .offer_vld   (ch_vld[c]),
            .offer_bytes (ch_offer[c]),
            .take_bytes  (ch_take[c]),
            .ctrl_o      (ch_ctrl[c]),
            .addr_o      (ch_addr[c]),
            .rem_o       (ch_rem[c]),
            .done_o      (ch_done[c]),
            .active_o    (ch_act[c])
        );
    end

    assign play_take_bytes = ch_take[0];
    assign cap_take_bytes  = ch_take[1];
    assign irq_play_done   = ch_done[0];
    assign irq_cap_done    = ch_done[1];
    assign play_active     = ch_act[0];
    assign cap_active      = ch_act[1];

    always_comb begin
        case (int'(slot))
            0:       bus_rdata = cc_q;
            1:       bus_rdata = ca_q;
            2:       bus_rdata = cdo_q;
            3:       bus_rdata = cdi_q;
            4:       bus_rdata = ch_ctrl[0];
            5:       bus_rdata = ch_addr[0];
            6:       bus_rdata = ch_rem[0];
            8:       bus_rdata = ch_ctrl[1];
            9:       bus_rdata = ch_addr[1];
            10:      bus_rdata = ch_rem[1];
            default: bus_rdata = '0;
        endcase
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot) == 7 || int'(slot) >= NUM_SLOTS) |-> bus_rdata == '0);
    assert_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hit[SLOT_PB]) |-> play_active == $past(bus_wdata[0]));
endmodule

// File: tb/aclink_ctrl_tb.sv
`timescale 1ns/1ps
module aclink_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_codec_req, irq_codec_rsp, irq_play_done, irq_cap_done;
    logic        play_active, cap_active;
    logic        play_offer_vld = 1'b0, cap_offer_vld = 1'b0;
    logic [15:0] play_offer_bytes = '0, cap_offer_bytes = '0;
    logic [15:0] play_take_bytes, cap_take_bytes;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m [16];

    always #10 clk = ~clk;

    aclink_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_codec_req(irq_codec_req), .irq_codec_rsp(irq_codec_rsp),
        .irq_play_done(irq_play_done), .irq_cap_done(irq_cap_done),
        .play_active(play_active), .play_offer_vld(play_offer_vld),
        .play_offer_bytes(play_offer_bytes), .play_take_bytes(play_take_bytes),
        .cap_active(cap_active), .cap_offer_vld(cap_offer_vld),
        .cap_offer_bytes(cap_offer_bytes), .cap_take_bytes(cap_take_bytes)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] take_of(input bit vld, input bit blk,
                                            input logic [31:0] rem, input logic [15:0] off);
        logic [31:0] o = {16'd0, off};
        if (!vld || blk) return 32'd0;
        return (rem < o) ? rem : o;
    endfunction

    function automatic string slot_tag(input int s);
        if (s == 7 || s > 10) return "R2";
        if (s == 0) return "R5";
        if (s == 5 || s == 6 || s == 9 || s == 10) return "R7";
        return "R1";
    endfunction

    task automatic read_all();
        for (int s = 0; s < 16; s++) begin
            bus_addr = {s[3:0], 2'(($urandom % 4))};
            #0.5;
            chk(slot_tag(s), bus_rdata, m[s]);
        end
    endtask

    task automatic do_cycle(input bit wr, input int slot, input logic [31:0] data,
                            input bit pv, input logic [15:0] pb,
                            input bit cv, input logic [15:0] cb);
        bit blk_p, blk_c, exp_req, exp_rsp, exp_pd, exp_cd;
        logic [31:0] tp, tc;
        bus_sel = wr; bus_we = wr;
        bus_addr = {slot[3:0], 2'(($urandom % 4))};
        bus_wdata = data;
        play_offer_vld = pv; play_offer_bytes = pb;
        cap_offer_vld = cv; cap_offer_bytes = cb;
        blk_p = wr && (slot == 5 || slot == 6);
        blk_c = wr && (slot == 9 || slot == 10);
        tp = take_of(pv, blk_p, m[6], pb);
        tc = take_of(cv, blk_c, m[10], cb);
        #2;
        chk(blk_p ? "R11" : ((pv && pb == 0) ? "R9" : "R6"), {16'd0, play_take_bytes}, tp);
        chk(blk_c ? "R11" : ((cv && cb == 0) ? "R9" : "R6"), {16'd0, cap_take_bytes}, tc);
        exp_req = wr && slot == 0 && data[0] && data[1];
        exp_rsp = wr && slot == 0 && data[0] && !data[1];
        exp_pd  = m[4][0] && tp != 0 && m[6] == tp;
        exp_cd  = m[8][0] && tc != 0 && m[10] == tc;
        if (wr) begin
            if (slot == 0) m[0] = data & ~32'd1;
            else if (slot <= 10 && slot != 7) m[slot] = data;
        end
        if (tp != 0) begin m[5] += tp; m[6] -= tp; end
        if (tc != 0) begin m[9] += tc; m[10] -= tc; end
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        chk("R3", {31'd0, irq_codec_req}, {31'd0, exp_req});
        chk("R4", {31'd0, irq_codec_rsp}, {31'd0, exp_rsp});
        chk("R8", {31'd0, irq_play_done}, {31'd0, exp_pd});
        chk("R8", {31'd0, irq_cap_done}, {31'd0, exp_cd});
        chk("R10", {31'd0, play_active}, {31'd0, m[4][0]});
        chk("R10", {31'd0, cap_active}, {31'd0, m[8][0]});
        read_all();
        @(negedge clk);
    endtask

    initial begin
        #(20.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        read_all();
        chk("R10", {30'd0, play_active, cap_active}, 32'd0);
        chk("R10", {28'd0, irq_codec_req, irq_codec_rsp, irq_play_done, irq_cap_done}, 32'd0);

        // R3/R4/R5 codec requests
        do_cycle(1, 0, 32'hA5A5_0003, 0, 0, 0, 0);
        do_cycle(1, 0, 32'h0000_0001, 0, 0, 0, 0);
        do_cycle(1, 0, 32'h0000_0006, 0, 0, 0, 0);
        do_cycle(0, 0, 0, 0, 0, 0, 0);
        // R2 reserved and out-of-range slots
        do_cycle(1, 7, 32'hFFFF_FFFF, 0, 0, 0, 0);
        do_cycle(1, 13, 32'h1234_5678, 0, 0, 0, 0);
        // R7/R8 playback: 100 bytes in 60 + 70 offer
        do_cycle(1, 5, 32'h0000_1000, 0, 0, 0, 0);
        do_cycle(1, 6, 32'd100, 0, 0, 0, 0);
        do_cycle(1, 4, 32'd1, 0, 0, 0, 0);
        do_cycle(0, 0, 0, 1, 16'd60, 0, 0);
        do_cycle(0, 0, 0, 1, 16'd70, 0, 0);
        do_cycle(0, 0, 0, 1, 16'd70, 0, 0);
        // R8 capture disabled reaches zero: no pulse
        do_cycle(1, 10, 32'd8, 0, 0, 0, 0);
        do_cycle(0, 0, 0, 0, 0, 1, 16'd8);
        // R9 zero-byte offer
        do_cycle(1, 10, 32'd8, 0, 0, 0, 0);
        do_cycle(1, 8, 32'd1, 0, 0, 0, 0);
        do_cycle(0, 0, 0, 0, 0, 1, 16'd0);
        // R11 bus write blocks transfer
        do_cycle(1, 10, 32'd20, 0, 0, 1, 16'd5);
        do_cycle(0, 0, 0, 0, 0, 1, 16'd20);

        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 10;
            int s = $urandom % 16;
            logic [31:0] d;
            bit w = (r < 4);
            if (s == 6 || s == 10) d = $urandom % 64;
            else if (s == 0) d = $urandom;
            else if (s == 4 || s == 8) d = ($urandom % 4 != 0) ? 32'd1 : 32'd0;
            else d = $urandom;
            do_cycle(w, s, d,
                     ($urandom % 10) < 7, 16'($urandom % 40),
                     ($urandom % 10) < 7, 16'($urandom % 40));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule